// File: doc/BRIEF.md
# Out-of-Order Context Symbol Dispatcher

This block sits in front of four binary arithmetic-coding cores. It takes a stream of context-labelled binary symbols and routes each symbol to the core that owns its context type. There is one core each for value/significance, sign, descendant set and grand-descendant set. Any core that is free gets work straight away. A symbol whose core is still busy does not hold up younger symbols bound for other cores, so up to four symbols leave in the same cycle.

Each accepted symbol is given a sequence tag. The cores finish in whatever order their latencies allow. A reorder buffer collects each core's result under the tag of the symbol it belongs to. It releases the results strictly in arrival order, one per cycle, so the code stream can be merged downstream.

The dispatcher admits a new symbol only while the waiting buffer has room and fewer than ROB_DEPTH symbols are between acceptance and release. This keeps every in-flight tag distinct. ROB_DEPTH must be a power of two.

Top module: `ctx_dispatch_ooo`

## Requirements
- R1: `in_ready` is low whenever the waiting buffer holds QDEPTH (8) symbols.
- R2: A symbol is issued only on the core port selected by context label bits [3:2]: 00 to core 0 (value/significance), 01 to core 1 (sign), 10 to core 2 (descendant set), 11 to core 3 (grand-descendant set).
- R3: Symbols of the same context type are issued to their core in the order they were accepted, with label and symbol bit unchanged.
- R4: No issue is made to a core whose `core_busy` is high, or that has received an issue without returning `core_done` since. A core returns `core_done` only while it holds work.
- R5: When all four cores are free and every type has a waiting symbol, all four are issued in the same cycle.
- R6: A waiting symbol blocked on a busy core does not prevent a younger symbol of another type from being issued.
- R7: Results leave on `out_valid` in acceptance order. `out_tag` counts 0, 1, 2, … modulo ROB_DEPTH from reset, and no result is released while an older one is missing.
- R8: `out_code` equals the `core_code` value that the core returned with `core_done` for that symbol.
- R9: During and right after reset, `in_ready` is high and `iss_valid` and `out_valid` are low.
- R10: A symbol accepted at a clock edge with its core free is presented on that core's issue port in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input symbol offered |
| in_ready | output | 1 | Input symbol accepted at this edge when valid |
| in_ctx | input | 4 | Context label; bits [3:2] give the type |
| in_sym | input | 1 | Binary symbol |
| iss_valid | output | 4 | One-cycle issue pulse per core |
| iss_ctx | output | 16 | Context label per core, core k at [4k+3:4k] |
| iss_sym | output | 4 | Symbol bit per core |
| core_busy | input | 4 | Core k cannot take new work |
| core_done | input | 4 | One-cycle completion pulse per core |
| core_code | input | 32 | Result per core, core k at [8k+7:8k] |
| out_valid | output | 1 | Ordered result available this cycle |
| out_tag | output | 4 | Sequence tag of the released result |
| out_code | output | 8 | Released result |

## Verification
The assertions assume that the cores follow the issue protocol. A core raises `core_done` for exactly one cycle, and only after it was issued a symbol and before it is issued another. Its `core_code` is valid in that cycle. The bench models each core as a responder that counts a latency drawn from the issued label and pulses done once when the count expires. It never raises done on an idle core. The bench drives `core_busy` only between edges, so forced stalls never break that ordering.

// File: rtl/ctxd_pkg.sv
// Shared constants for the context dispatcher: label width, core count and
// the mapping from a context label to its type (and thus its core).
package ctxd_pkg;
    localparam int CTX_W  = 4;
    localparam int TYPE_W = 2;
    localparam int N_CORE = 1 << TYPE_W;

    // Type field sits in the top bits of the label.
    function automatic logic [TYPE_W-1:0] ctx_type(input logic [CTX_W-1:0] c);
        return c[CTX_W-1 -: TYPE_W];
    endfunction
endpackage

// File: rtl/ctxd_queue.sv
// Waiting buffer. Entries are kept compacted in age order (index 0 oldest).
// Each cycle the oldest entry of every type is offered to its core; entries
// whose core is free are removed and the survivors shift down.
// Assumes push is never asserted while full.
module ctxd_queue
    import ctxd_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int TAG_W  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [CTX_W-1:0]                 push_ctx,
    input  logic                             push_sym,
    input  logic [TAG_W-1:0]                 push_tag,
    input  logic [N_CORE-1:0]                core_free,
    output logic                             full,
    output logic [$clog2(QDEPTH+1)-1:0]      count,
    output logic [N_CORE-1:0]                iss_valid,
    output logic [N_CORE-1:0][CTX_W-1:0]     iss_ctx,
    output logic [N_CORE-1:0]                iss_sym,
    output logic [N_CORE-1:0][TAG_W-1:0]     iss_tag
);
    localparam int IDX_W = $clog2(QDEPTH);
    localparam int CNT_W = $clog2(QDEPTH+1);

    logic [QDEPTH-1:0]             q_v, n_v, rm;
    logic [QDEPTH-1:0][CTX_W-1:0]  q_ctx, n_ctx;
    logic [QDEPTH-1:0]             q_sym, n_sym;
    logic [QDEPTH-1:0][TAG_W-1:0]  q_tag, n_tag;
    logic [N_CORE-1:0]             hit;
    logic [CNT_W-1:0]              dst;

    // Pick the oldest waiting entry of each type and mark it for removal.
    always_comb begin
        rm        = '0;
        hit       = '0;
        iss_ctx   = '0;
        iss_sym   = '0;
        iss_tag   = '0;
        for (int t = 0; t < N_CORE; t++) begin
            for (int i = 0; i < QDEPTH; i++) begin
                if (!hit[t] && q_v[i] && ctx_type(q_ctx[i]) == TYPE_W'(t)) begin
                    hit[t]     = 1'b1;
                    iss_ctx[t] = q_ctx[i];
                    iss_sym[t] = q_sym[i];
                    iss_tag[t] = q_tag[i];
                    rm[i]      = core_free[t];
                end
            end
        end
        iss_valid = hit & core_free;
    end

    // Compact the survivors toward index 0, then append the new entry.
    always_comb begin
        n_v   = '0;
        n_ctx = q_ctx;
        n_sym = q_sym;
        n_tag = q_tag;
        dst   = '0;
        for (int i = 0; i < QDEPTH; i++) begin
            if (q_v[i] && !rm[i]) begin
                n_v[dst[IDX_W-1:0]]   = 1'b1;
                n_ctx[dst[IDX_W-1:0]] = q_ctx[i];
                n_sym[dst[IDX_W-1:0]] = q_sym[i];
                n_tag[dst[IDX_W-1:0]] = q_tag[i];
                dst = dst + CNT_W'(1);
            end
        end
        if (push && dst < CNT_W'(QDEPTH)) begin
            n_v[dst[IDX_W-1:0]]   = 1'b1;
            n_ctx[dst[IDX_W-1:0]] = push_ctx;
            n_sym[dst[IDX_W-1:0]] = push_sym;
            n_tag[dst[IDX_W-1:0]] = push_tag;
        end
    end

    // Occupancy count of the compacted buffer.
    always_comb begin
        count = '0;
        for (int i = 0; i < QDEPTH; i++) count = count + CNT_W'(q_v[i]);
    end

    assign full = q_v[QDEPTH-1];

    // Buffer storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_v   <= '0;
            q_ctx <= '0;
            q_sym <= '0;
            q_tag <= '0;
        end else begin
            q_v   <= n_v;
            q_ctx <= n_ctx;
            q_sym <= n_sym;
            q_tag <= n_tag;
        end
    end
endmodule

// File: rtl/ctxd_core_track.sv
// Per-core state register: idle, or the label and tag of the symbol the core
// is working on. Assumes done arrives only while working and never together
// with an issue.
module ctxd_core_track
    import ctxd_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [CTX_W-1:0]  issue_ctx,
    input  logic [TAG_W-1:0]  issue_tag,
    input  logic              done,
    output logic              busy,
    output logic [CTX_W-1:0]  cur_ctx,
    output logic [TAG_W-1:0]  cur_tag
);
    typedef enum logic {TRK_IDLE, TRK_WORK} trk_state_e;
    trk_state_e st;

    // Take work on issue, release it on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= TRK_IDLE;
            cur_ctx <= '0;
            cur_tag <= '0;
        end else if (issue) begin
            st      <= TRK_WORK;
            cur_ctx <= issue_ctx;
            cur_tag <= issue_tag;
        end else if (done) begin
            st      <= TRK_IDLE;
        end
    end

    assign busy = (st == TRK_WORK);
endmodule

// File: rtl/ctxd_rob.sv
// Reorder buffer indexed by sequence tag. Cores write results under the tag
// of their symbol; the slot at the head is released when filled.
// Assumes DEPTH is a power of two and that in-flight tags are distinct.
module ctxd_rob
    import ctxd_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CODE_W = 8,
    parameter int TAG_W  = $clog2(DEPTH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_CORE-1:0]                wr_en,
    input  logic [N_CORE-1:0][TAG_W-1:0]     wr_tag,
    input  logic [N_CORE-1:0][CODE_W-1:0]    wr_code,
    output logic                             out_valid,
    output logic [TAG_W-1:0]                 out_tag,
    output logic [CODE_W-1:0]                out_code
);
    logic [DEPTH-1:0]              slot_v;
    logic [DEPTH-1:0][CODE_W-1:0]  slot_code;
    logic [TAG_W-1:0]              head;

    assign out_valid = slot_v[head];
    assign out_tag   = head;
    assign out_code  = slot_code[head];

    // Release the head when filled and record completed results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v    <= '0;
            slot_code <= '0;
            head      <= '0;
        end else begin
            if (out_valid) begin
                slot_v[head] <= 1'b0;
                head         <= head + TAG_W'(1);
            end
            for (int k = 0; k < N_CORE; k++) begin
                if (wr_en[k]) begin
                    slot_v[wr_tag[k]]    <= 1'b1;
                    slot_code[wr_tag[k]] <= wr_code[k];
                end
            end
        end
    end
endmodule

// File: rtl/ctx_dispatch_ooo.sv
// Top: tags accepted symbols, holds them in the waiting buffer, issues them
// out of order to free per-type cores and restores order on the results.
// Assumes cores obey the issue/done protocol described in the brief.
module ctx_dispatch_ooo
    import ctxd_pkg::*;
#(
    parameter int QDEPTH    = 8,
    parameter int ROB_DEPTH = 16,
    parameter int CODE_W    = 8,
    localparam int TAG_W    = $clog2(ROB_DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [CTX_W-1:0]           in_ctx,
    input  logic                       in_sym,
    output logic [N_CORE-1:0]          iss_valid,
    output logic [N_CORE*CTX_W-1:0]    iss_ctx,
    output logic [N_CORE-1:0]          iss_sym,
    input  logic [N_CORE-1:0]          core_busy,
    input  logic [N_CORE-1:0]          core_done,
    input  logic [N_CORE*CODE_W-1:0]   core_code,
    output logic                       out_valid,
    output logic [TAG_W-1:0]           out_tag,
    output logic [CODE_W-1:0]          out_code
);
    localparam int FL_W  = $clog2(ROB_DEPTH+1);
    localparam int CNT_W = $clog2(QDEPTH+1);

    logic                            accept, q_full;
    logic [CNT_W-1:0]                q_count;
    logic [TAG_W-1:0]                next_tag;
    logic [FL_W-1:0]                 inflight;
    logic [N_CORE-1:0]               trk_busy, core_free;
    logic [N_CORE-1:0][CTX_W-1:0]    iss_ctx_a, trk_ctx;
    logic [N_CORE-1:0][TAG_W-1:0]    q_iss_tag, trk_tag;
    logic [N_CORE-1:0][CODE_W-1:0]   code_a;

    assign in_ready  = !q_full && (inflight < FL_W'(ROB_DEPTH));
    assign accept    = in_valid && in_ready;
    assign core_free = ~trk_busy & ~core_busy;
    assign iss_ctx   = iss_ctx_a;
    assign code_a    = core_code;

    // Sequence tag allocation and count of symbols not yet released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_tag <= '0;
            inflight <= '0;
        end else begin
            next_tag <= next_tag + TAG_W'(accept);
            inflight <= inflight + FL_W'(accept) - FL_W'(out_valid);
        end
    end

    ctxd_queue #(.QDEPTH(QDEPTH), .TAG_W(TAG_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .push_ctx  (in_ctx),
        .push_sym  (in_sym),
        .push_tag  (next_tag),
        .core_free (core_free),
        .full      (q_full),
        .count     (q_count),
        .iss_valid (iss_valid),
        .iss_ctx   (iss_ctx_a),
        .iss_sym   (iss_sym),
        .iss_tag   (q_iss_tag)
    );

    for (genvar k = 0; k < N_CORE; k++) begin : g_trk
        ctxd_core_track #(.TAG_W(TAG_W)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue     (iss_valid[k]),
            .issue_ctx (iss_ctx_a[k]),
            .issue_tag (q_iss_tag[k]),
            .done      (core_done[k]),
            .busy      (trk_busy[k]),
            .cur_ctx   (trk_ctx[k]),
            .cur_tag   (trk_tag[k])
        );
    end

    ctxd_rob #(.DEPTH(ROB_DEPTH), .CODE_W(CODE_W), .TAG_W(TAG_W)) u_rob (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (core_done),
        .wr_tag    (trk_tag),
        .wr_code   (code_a),
        .out_valid (out_valid),
        .out_tag   (out_tag),
        .out_code  (out_code)
    );
endmodule

// File: rtl/ctxd_checker.sv
// Protocol and ordering properties of the dispatcher, bound to the top.
module ctxd_checker
    import ctxd_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int TAG_W  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_ready,
    input logic [$clog2(QDEPTH+1)-1:0]   q_count,
    input logic [N_CORE-1:0]             iss_valid,
    input logic [N_CORE*CTX_W-1:0]       iss_ctx,
    input logic [N_CORE-1:0]             core_busy,
    input logic [N_CORE-1:0]             core_done,
    input logic [N_CORE-1:0]             trk_busy,
    input logic [N_CORE-1:0][CTX_W-1:0]  trk_ctx,
    input logic                          out_valid,
    input logic [TAG_W-1:0]              out_tag
);
    logic [TAG_W-1:0] exp_tag;

    // Independent count of released results.
    always_ff @(posedge clk) begin
        if (!rst_n) exp_tag <= '0;
        else if (out_valid) exp_tag <= exp_tag + TAG_W'(1);
    end

    assert_full_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q_count == ($bits(q_count))'(QDEPTH) |-> !in_ready);

    assert_release_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tag == exp_tag);

    for (genvar k = 0; k < N_CORE; k++) begin : g_core
        assert_route_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k] |-> iss_ctx[k*CTX_W+CTX_W-1 -: TYPE_W] == TYPE_W'(k));
        assert_held_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
            trk_busy[k] |-> ctx_type(trk_ctx[k]) == TYPE_W'(k));
        assert_no_issue_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k] |-> !core_busy[k] && !trk_busy[k]);
        assert_issue_takes_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k] |=> trk_busy[k]);
        assert_done_has_work_R4: assert property (@(posedge clk) disable iff (!rst_n)
            core_done[k] |-> trk_busy[k]);
    end
endmodule

bind ctx_dispatch_ooo ctxd_checker #(.QDEPTH(QDEPTH), .TAG_W(TAG_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .q_count   (q_count),
    .iss_valid (iss_valid),
    .iss_ctx   (iss_ctx),
    .core_busy (core_busy),
    .core_done (core_done),
    .trk_busy  (trk_busy),
    .trk_ctx   (trk_ctx),
    .out_valid (out_valid),
    .out_tag   (out_tag)
);

// File: tb/test_ctx_dispatch_ooo.sv
// Bench: core models with label-dependent latency, issue and release monitors,
// a vector table walk and directed corner tests.
module test_ctx_dispatch_ooo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_ctx = '0;
    logic        in_sym = 1'b0;
    logic [3:0]  iss_valid;
    logic [15:0] iss_ctx;
    logic [3:0]  iss_sym;
    logic [3:0]  core_busy = '0;
    logic [3:0]  core_done = '0;
    logic [31:0] core_code = '0;
    logic        out_valid;
    logic [3:0]  out_tag;
    logic [7:0]  out_code;

    always #2 clk = ~clk;   // 250 MHz

    ctx_dispatch_ooo i_ctx_dispatch_ooo (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ctx(in_ctx), .in_sym(in_sym), .iss_valid(iss_valid), .iss_ctx(iss_ctx),
        .iss_sym(iss_sym), .core_busy(core_busy), .core_done(core_done),
        .core_code(core_code), .out_valid(out_valid), .out_tag(out_tag),
        .out_code(out_code)
    );

    // Stimulus table: {context label, symbol}
    localparam logic [4:0] VEC [24] = '{
        5'b0000_1, 5'b0111_0, 5'b1010_1, 5'b1101_1, 5'b0010_0, 5'b0001_1,
        5'b1111_0, 5'b0100_1, 5'b1000_0, 5'b0011_1, 5'b0110_0, 5'b1100_1,
        5'b1011_1, 5'b0101_0, 5'b1110_1, 5'b0000_0, 5'b0000_1, 5'b1001_0,
        5'b0111_1, 5'b1101_0, 5'b0011_0, 5'b1010_0, 5'b0100_0, 5'b1111_1 };

    int checks = 0, fails = 0;
    int n_push = 0, n_out = 0;
    logic [7:0] exp_code [256];
    logic [3:0] tq_c [4][64];
    logic       tq_s [4][64];
    int tq_wr [4] = '{0, 0, 0, 0};
    int tq_rd [4] = '{0, 0, 0, 0};
    int cnt [4]   = '{0, 0, 0, 0};
    int iss_cnt [4] = '{0, 0, 0, 0};
    logic [3:0] hc [4];
    logic       hs [4];

    function automatic logic [7:0] code_of(input logic [3:0] c, input logic s);
        return {~c, s, c[0] ^ s, c[3], 1'b1};
    endfunction

    function automatic int lat_of(input logic [3:0] c);
        return 1 + 2 * int'(c[1:0]) + int'(c[3]);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Core models and output monitor, all sampled at the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            core_done = '0;
            for (int k = 0; k < 4; k++) cnt[k] = 0;
        end else begin
            for (int k = 0; k < 4; k++) begin
                core_done[k] = 1'b0;
                if (cnt[k] > 0) begin
                    cnt[k]--;
                    if (cnt[k] == 0) begin
                        core_done[k] = 1'b1;
                        core_code[k*8 +: 8] = code_of(hc[k], hs[k]);
                    end
                end
                if (iss_valid[k]) begin
                    hc[k] = iss_ctx[k*4 +: 4];
                    hs[k] = iss_sym[k];
                    cnt[k] = lat_of(hc[k]);
                    iss_cnt[k]++;
                    chk(hc[k][3:2] == 2'(k), "R2", "issue port type",
                        int'(hc[k][3:2]), k);
                    chk({hc[k], hs[k]} == {tq_c[k][tq_rd[k]], tq_s[k][tq_rd[k]]},
                        "R3", "per-type issue order",
                        int'({hc[k], hs[k]}), int'({tq_c[k][tq_rd[k]], tq_s[k][tq_rd[k]]}));
                    tq_rd[k]++;
                end
            end
            if (out_valid) begin
                chk(out_tag == 4'(n_out), "R7", "release tag", int'(out_tag), n_out % 16);
                chk(out_code == exp_code[n_out], "R8", "release code",
                    int'(out_code), int'(exp_code[n_out]));
                n_out++;
            end
        end
    end

    // Offer one symbol from posedge+1 and return one step after its accepting edge.
    task automatic send(input logic [3:0] c, input logic s);
        in_valid = 1'b1;
        in_ctx   = c;
        in_sym   = s;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        exp_code[n_push] = code_of(c, s);
        n_push++;
        tq_c[c[3:2]][tq_wr[c[3:2]]] = c;
        tq_s[c[3:2]][tq_wr[c[3:2]]] = s;
        tq_wr[c[3:2]]++;
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int w = 0;
        while (n_out < n_push && w < 600) begin
            @(negedge clk); #1;
            w++;
        end
        @(posedge clk); #1;
        chk(n_out == n_push, req, "all results released", n_out, n_push);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int a, b, o, tot;
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready == 1'b1, "R9", "in_ready in reset", int'(in_ready), 1);
        chk(iss_valid == 4'b0, "R9", "iss_valid in reset", int'(iss_valid), 0);
        chk(out_valid == 1'b0, "R9", "out_valid in reset", int'(out_valid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && iss_valid == 4'b0 && out_valid == 1'b0, "R9",
            "idle after reset", int'({in_ready, iss_valid, out_valid}), 32);
        @(posedge clk); #1;

        // R10: issue in the cycle after acceptance
        send(4'h5, 1'b1);
        @(negedge clk);
        chk(iss_valid == 4'b0010, "R10", "issue one cycle after accept",
            int'(iss_valid), 2);
        drain("R10");

        // Table walk: back-to-back symbols of mixed types (R2, R3, R7, R8)
        for (int i = 0; i < 24; i++) send(VEC[i][4:1], VEC[i][0]);
        drain("R7");

        // R1: stall every core and fill the waiting buffer
        core_busy = 4'hF;
        tot = iss_cnt[0] + iss_cnt[1] + iss_cnt[2] + iss_cnt[3];
        for (int i = 0; i < 8; i++) send(4'(i * 5), 1'(i));
        @(negedge clk);
        chk(in_ready == 1'b0, "R1", "in_ready with buffer full", int'(in_ready), 0);
        chk(iss_cnt[0] + iss_cnt[1] + iss_cnt[2] + iss_cnt[3] == tot, "R4",
            "no issue while core_busy",
            iss_cnt[0] + iss_cnt[1] + iss_cnt[2] + iss_cnt[3], tot);
        @(posedge clk); #1;
        core_busy = 4'h0;
        drain("R1");

        // R5: one waiting symbol per type, all released together
        core_busy = 4'hF;
        send(4'h2, 1'b0);
        send(4'h6, 1'b1);
        send(4'hA, 1'b1);
        send(4'hE, 1'b0);
        @(posedge clk); #1;
        core_busy = 4'h0;
        @(negedge clk);
        chk($countones(iss_valid) == 4, "R5", "four issues in one cycle",
            $countones(iss_valid), 4);
        drain("R5");

        // R6: blocked older type-0 symbol, younger type-1 goes ahead
        core_busy = 4'b0001;
        a = iss_cnt[0];
        b = iss_cnt[1];
        o = n_out;
        send(4'h1, 1'b0);
        send(4'h4, 1'b1);
        repeat (12) @(posedge clk);
        #1;
        chk(iss_cnt[1] == b + 1, "R6", "younger type issued past blocked", iss_cnt[1], b + 1);
        chk(iss_cnt[0] == a, "R4", "blocked core not issued", iss_cnt[0], a);
        chk(n_out == o, "R7", "younger result held behind older", n_out, o);
        core_busy = 4'h0;
        drain("R6");

        // R3: several same-type symbols queued behind a stalled core
        core_busy = 4'b0100;
        send(4'h8, 1'b1);
        send(4'h9, 1'b0);
        send(4'hB, 1'b1);
        send(4'h8, 1'b0);
        @(posedge clk); #1;
        core_busy = 4'h0;
        drain("R3");
        for (int k = 0; k < 4; k++)
            chk(tq_rd[k] == tq_wr[k], "R3", "per-type issue count", tq_rd[k], tq_wr[k]);

        finish_run();
    end
endmodule